// File: doc/BRIEF.md
# Serial-In Latched Display Driver

This block is the digital core of a multi-channel display tube driver. Display bits arrive one at a time on a serial data pin and are clocked by an external shift clock. A separate strobe copies the shifted pattern into an output register, which then feeds one driver output per channel. The last shift stage comes out on a serial pin, so several drivers can be chained to build a wider display.

The external shift clock and strobe are not used as clocks. Each is sampled on the single system clock through a two-flop synchroniser, and its rising edge is found by comparing the current sample with the one before. Two level controls sit in front of every output. The show-enable control blanks the display when it is low. The lamp-test control lights every channel when show-enable is high.

The system reset clears only the synchronisers. The shift and output registers are left undefined. To bring them to zero, the driver raises the strobe and then gives one shift clock edge while the strobe is still high. This is done before any other display data is loaded.

Top module: `slx_display_driver`

## Requirements
- R1: The shift register and the output register each hold `CH` bits (default 60). Bit index 0 is the first stage. Driver output `drv_out[k]` belongs to stage k+1.
- R2: A rising edge of `shift_clk` while the synchronised strobe is low shifts the register by one position. Stage index 0 takes `ser_in`, and stage k takes the old stage k-1. The shift takes effect within three system clock cycles of the pin edge.
- R3: `ser_out` always equals the last shift stage, index `CH-1`.
- R4: A rising edge of `strobe` copies all shift stages into the output register. Apart from the clear case, the output register holds its value at all other times, including while shifting.
- R5: A rising edge of `shift_clk` while the synchronised strobe is high sets every shift stage and every output register bit to zero. This clear takes priority over a load in the same cycle.
- R6: When `show_en` is low, every bit of `drv_out` is 0, whatever `lamp_test` and the register contents are.
- R7: When `show_en` is high and `lamp_test` is high, every bit of `drv_out` is 1.
- R8: When `show_en` is high and `lamp_test` is low, each `drv_out[k]` equals output register bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the synchronisers |
| shift_clk | input | 1 | External shift clock, sampled, acts on its rising edge |
| strobe | input | 1 | External load strobe, sampled; a rising edge loads, a high level turns shift edges into clears |
| ser_in | input | 1 | Serial display data |
| show_en | input | 1 | Low blanks all outputs |
| lamp_test | input | 1 | High lights all outputs while show_en is high |
| ser_out | output | 1 | Last shift stage, for cascading |
| drv_out | output | CH | Per-channel driver levels |

## Verification
The bench first gives the strobe-plus-shift clear, then loads random frames and compares every output with a bench model. A design that shifts in the wrong direction or loads the strobe level instead of its edge would show stale or shuffled channels. Shifting a second frame without a strobe catches an output register that leaks shift data. A clear given after a loaded frame catches a design that clears only one of the two registers. A design that ignores the priority of show-enable over lamp-test is caught with show-enable low and lamp-test high, because it would light outputs that must stay dark.

// File: rtl/slx_pkg.sv
package slx_pkg;

    localparam int unsigned CH_DEFAULT   = 60;
    localparam int unsigned SYNC_DEFAULT = 2;

    typedef enum logic [1:0] {
        MODE_BLANK = 2'd0,
        MODE_DATA  = 2'd1,
        MODE_TEST  = 2'd2
    } drive_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
    } pin_evt_t;

    // show-enable dominates, then lamp test, then data
    function automatic drive_mode_e decode_mode(input logic en, input logic test);
        if (!en)      return MODE_BLANK;
        else if (test) return MODE_TEST;
        else          return MODE_DATA;
    endfunction

endpackage

// File: rtl/slx_edge_sync.sv
module slx_edge_sync
    import slx_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEFAULT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output pin_evt_t evt
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign evt.level = chain[LAST];
    assign evt.rise  = chain[LAST] & ~prev;

    assert_rise_then_high_R2: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> prev);

endmodule

// File: rtl/slx_shift_latch.sv
module slx_shift_latch
    import slx_pkg::*;
#(
    parameter int unsigned CH = CH_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_evt_t      sclk,
    input  pin_evt_t      stb,
    input  logic          din,
    output logic [CH-1:0] stages,
    output logic [CH-1:0] held
);
    logic do_clear;
    logic do_shift;
    logic do_load;

    assign do_clear = sclk.rise & stb.level;
    assign do_shift = sclk.rise & ~stb.level;
    assign do_load  = stb.rise & ~do_clear;

    // registers intentionally not reset; a clear sequence defines them
    always_ff @(posedge clk) begin
        if (do_clear)      stages <= '0;
        else if (do_shift) stages <= {stages[CH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (do_clear)     held <= '0;
        else if (do_load) held <= stages;
    end

    assert_clear_both_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk.rise && stb.level) |=> (stages == '0 && held == '0));

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        (sclk.rise && !stb.level) |=> (stages[0] == $past(din)
                                       && stages[CH-1:1] == $past(stages[CH-2:0])));

    assert_load_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (stb.rise && !sclk.rise) |=> held == $past(stages));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!stb.rise && !sclk.rise) |=> $stable(held));

endmodule

// File: rtl/slx_out_ctrl.sv
module slx_out_ctrl
    import slx_pkg::*;
#(
    parameter int unsigned CH = CH_DEFAULT
) (
    input  logic          en,
    input  logic          test,
    input  logic [CH-1:0] held,
    output logic [CH-1:0] drv
);
    drive_mode_e mode;

    assign mode = decode_mode(en, test);

    generate
        for (genvar k = 0; k < CH; k++) begin : g_ch
            always_comb begin
                unique case (mode)
                    MODE_TEST: drv[k] = 1'b1;
                    MODE_DATA: drv[k] = held[k];
                    default:   drv[k] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/slx_display_driver.sv
module slx_display_driver
    import slx_pkg::*;
#(
    parameter int unsigned CH    = CH_DEFAULT,
    parameter int unsigned SYNCS = SYNC_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_clk,
    input  logic          strobe,
    input  logic          ser_in,
    input  logic          show_en,
    input  logic          lamp_test,
    output logic          ser_out,
    output logic [CH-1:0] drv_out
);
    pin_evt_t      sclk_evt;
    pin_evt_t      stb_evt;
    logic [CH-1:0] stages;
    logic [CH-1:0] held;

    slx_edge_sync #(.STAGES(SYNCS)) u_sync_sclk (
        .clk(clk), .rst(rst), .pin(shift_clk), .evt(sclk_evt)
    );

    slx_edge_sync #(.STAGES(SYNCS)) u_sync_stb (
        .clk(clk), .rst(rst), .pin(strobe), .evt(stb_evt)
    );

    slx_shift_latch #(.CH(CH)) u_core (
        .clk(clk), .rst(rst), .sclk(sclk_evt), .stb(stb_evt),
        .din(ser_in), .stages(stages), .held(held)
    );

    slx_out_ctrl #(.CH(CH)) u_outs (
        .en(show_en), .test(lamp_test), .held(held), .drv(drv_out)
    );

    assign ser_out = stages[CH-1];

    assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
        !show_en |-> drv_out == '0);

    assert_lamp_R7: assert property (@(posedge clk) disable iff (rst)
        (show_en && lamp_test) |-> &drv_out);

    assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (show_en && !lamp_test) |-> drv_out == held);

endmodule

// File: tb/slx_display_driver_bench.sv
module slx_display_driver_bench;
    localparam int CH = 60;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shift_clk = 1'b0;
    logic          strobe = 1'b0;
    logic          ser_in = 1'b0;
    logic          show_en = 1'b0;
    logic          lamp_test = 1'b0;
    logic          ser_out;
    logic [CH-1:0] drv_out;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cycles = 0;
    bit          done = 1'b0;

    logic [CH-1:0] m_sr;
    logic [CH-1:0] m_lat;

    always #4 clk = ~clk;

    slx_display_driver #(.CH(CH)) u_slx_display_driver (
        .clk(clk), .rst(rst), .shift_clk(shift_clk), .strobe(strobe),
        .ser_in(ser_in), .show_en(show_en), .lamp_test(lamp_test),
        .ser_out(ser_out), .drv_out(drv_out)
    );

    function automatic logic [CH-1:0] exp_drv(input logic [CH-1:0] lat,
                                              input logic en, input logic tst);
        if (!en)      return '0;
        else if (tst) return '1;
        else          return lat;
    endfunction

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check_outs(input string req);
        logic [CH-1:0] e;
        e = exp_drv(m_lat, show_en, lamp_test);
        checks++;
        if (drv_out !== e) begin
            errors++;
            $display("FAIL %s: drv_out got %h expected %h", req, drv_out, e);
        end
        checks++;
        if (ser_out !== m_sr[CH-1]) begin
            errors++;
            $display("FAIL R3: ser_out got %b expected %b", ser_out, m_sr[CH-1]);
        end
    endtask

    // one shift clock pulse; model follows R2 / R5
    task automatic shift_bit(input logic b);
        ser_in = b;
        wait_clks(4);
        shift_clk = 1'b1;
        wait_clks(5);
        if (strobe) begin
            m_sr  = '0;
            m_lat = '0;
        end else begin
            m_sr = {m_sr[CH-2:0], b};
        end
        shift_clk = 1'b0;
        wait_clks(4);
    endtask

    task automatic pulse_strobe();
        strobe = 1'b1;
        wait_clks(5);
        m_lat = m_sr;
        strobe = 1'b0;
        wait_clks(4);
    endtask

    task automatic clear_seq();
        strobe = 1'b1;
        wait_clks(5);
        m_lat = m_sr;
        shift_bit($urandom_range(0, 1));
        strobe = 1'b0;
        wait_clks(4);
    endtask

    task automatic load_frame(input bit dense);
        for (int i = 0; i < CH; i++) begin
            logic b;
            b = dense ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
            shift_bit(b);
            check_outs("R2");
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: cycles got %0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5A17_0C3E);
        m_sr  = '0;
        m_lat = '0;
        wait_clks(4);
        rst = 1'b0;
        wait_clks(3);

        // R5: clear sequence defines both registers as zero
        clear_seq();
        m_sr = '0; m_lat = '0;
        show_en = 1'b1;
        wait_clks(1);
        check_outs("R5");

        // R1 R2 R4 R8: random frames
        for (int f = 0; f < 3; f++) begin
            load_frame(f[0]);
            pulse_strobe();
            check_outs("R4");
        end

        // R1: single marker bit lands on channel 0 after one shift, last after CH
        clear_seq();
        shift_bit(1'b1);
        pulse_strobe();
        check_outs("R1");
        for (int i = 0; i < CH - 1; i++) shift_bit(1'b0);
        check_outs("R3");
        pulse_strobe();
        check_outs("R1");

        // R4: new frame shifted without a strobe leaves outputs unchanged
        load_frame(1'b1);
        check_outs("R4");

        // R6 R7 R8 control combinations
        show_en = 1'b0; lamp_test = 1'b0; wait_clks(1); check_outs("R6");
        show_en = 1'b0; lamp_test = 1'b1; wait_clks(1); check_outs("R6");
        show_en = 1'b1; lamp_test = 1'b1; wait_clks(1); check_outs("R7");
        show_en = 1'b1; lamp_test = 1'b0; wait_clks(1); check_outs("R8");
        pulse_strobe();
        check_outs("R8");

        // R5: clear after loaded data zeroes both registers
        clear_seq();
        check_outs("R5");
        lamp_test = 1'b1; wait_clks(1); check_outs("R7");
        lamp_test = 1'b0; wait_clks(1); check_outs("R5");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule